// File: doc/BRIEF.md
# Microcontroller Fetch-Execute Sequencer

This block is the control core of a small 8-bit microcontroller. It does not hold program memory, data memory, the arithmetic unit or the opcode decoder. It drives each of them over its own group of ports and steps the machine through three outer phases: reset initialisation, instruction fetch/decode, and execute. Each phase is timed by an inner 3-bit step counter, whose steps are called ES0 to ES7.

Program memory and data memory answer a read strobe with a fixed latency. The sequencer samples the read byte on the third step after the strobe, which is the only step in which the data is valid. The program counter is never incremented locally. Each advance is an unsigned-add request to the arithmetic unit, and the sum comes back on the result port. The decoder returns a 9-bit word with these fields:

- bits 6:0 hold an execution pointer;
- bit 7 requests a second instruction byte;
- bit 8 sets the program-counter step applied after the third byte.

Two instructions are executed in full:

- a rotate of the accumulator left through the carry;
- a move of the accumulator to a direct address taken from the second byte.

Every other pointer is treated as a no-operation.

Top module: `mcu_fetch_exec_seq`

## Requirements
- R1: While rstN is low, romRd, ramRd and ramWr are 0, aluOp is 0 and romAddr is 0.
- R2: In the cycles 0 to 4 after reset release, the block writes FFh to the port registers at addresses 80h, 90h, A0h and B0h, then 07h to the stack pointer at 81h, one write per cycle in that order. Cycle 5 is idle, and the first opcode fetch is in cycle 6 at address 0.
- R3: Fetch step ES0 strobes romRd at romAddr = PC and requests aluOp = 1 (program-counter add) with aluA = PC and aluB = 1. The PC takes aluResult.
- R4: In fetch step ES3 the decoder sees the opcode byte on decIn. If decOut bit 7 is 1, the block strobes romRd at the advanced PC and requests another add of 1. If bit 7 is 0, there is no strobe in ES3.
- R5: Fetch step ES4 always strobes romRd at the current PC and requests aluOp = 1 with aluB = decOut bit 8 as latched in ES3. Over a fetch, the PC therefore advances by 1 + bit 7 + bit 8.
- R6: ROM and RAM read data are sampled exactly three steps after the read strobe. Fetch reads the accumulator (E0h) in ES1 and the status word (D0h) in ES2.
- R7: Pointer 1 is the rotate. In execute ES0 the block drives aluOp = Bh, aluA = accumulator and aluCin = status bit 7. In ES1 it writes the result to E0h. In ES2 it writes D0h with bit 7 set to the returned carry and bits 6:0 unchanged.
- R8: Pointer 2 is the move. In execute ES0 the block writes the accumulator to the address held in the second instruction byte. aluOp stays 0 throughout execute.
- R9: For pointers 1 and 2, execution runs to ES7 with aluOp = 0 there, and the next opcode fetch follows 16 cycles after the previous one.
- R10: Any other pointer leaves execute after ES0 without a RAM write, so the next opcode fetch is 9 cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| romAddr | output | 12 | Program memory address (the PC) |
| romRd | output | 1 | Program memory read strobe |
| romData | input | 8 | Program memory read data |
| ramAddr | output | 8 | Data memory / special register address |
| ramRd | output | 1 | Data memory read strobe |
| ramWr | output | 1 | Data memory write strobe |
| ramWrData | output | 8 | Data memory write data |
| ramRdData | input | 8 | Data memory read data |
| aluOp | output | 4 | Arithmetic unit operation: 0 none, 1 PC add, Bh rotate through carry |
| aluA | output | 12 | Arithmetic unit first operand |
| aluB | output | 8 | Arithmetic unit second operand |
| aluCin | output | 1 | Carry into the arithmetic unit |
| aluResult | input | 12 | Arithmetic unit result |
| aluCarry | input | 1 | Arithmetic unit carry out |
| decIn | output | 8 | Opcode byte to the decoder |
| decOut | input | 9 | Decoder word: pointer, second-byte flag, third-step flag |

## Verification
A wrong step count or a wrong phase shows up on the next strobe. A read strobe or opcode fetch lands in the wrong cycle, and the bench compares every cycle's romRd, ramRd and ramWr with the expected pattern. A capture made one step early or late picks up the poison byte that the bench memories return outside the single valid cycle. That error appears within one instruction as a wrong write value or a wrong PC. A PC that drifts through a wrong add amount shows up at the next opcode fetch address.

// File: rtl/mcu_seq_pkg.sv
package mcu_seq_pkg;

  typedef enum logic [1:0] {
    CPU_RST   = 2'd0,
    CPU_FETCH = 2'd1,
    CPU_EXEC  = 2'd2
  } cpuState_t;

  typedef enum logic [1:0] {
    WR_CONST = 2'd0,
    WR_ACC   = 2'd1,
    WR_ALU   = 2'd2,
    WR_PSW   = 2'd3
  } wrSel_t;

  localparam int ES_W      = 3;
  localparam int NUM_PORTS = 4;

  localparam logic [3:0] ALU_NONE  = 4'h0;
  localparam logic [3:0] ALU_PCADD = 4'h1;
  localparam logic [3:0] ALU_RLC   = 4'hB;

  localparam logic [7:0] ADDR_ACC    = 8'hE0;
  localparam logic [7:0] ADDR_PSW    = 8'hD0;
  localparam logic [7:0] ADDR_SP     = 8'h81;
  localparam logic [7:0] PORT_BASE   = 8'h80;
  localparam logic [7:0] PORT_STRIDE = 8'h10;
  localparam logic [7:0] PORT_INIT   = 8'hFF;
  localparam logic [7:0] SP_INIT     = 8'h07;

  localparam logic [6:0] PTR_RLC  = 7'd1;
  localparam logic [6:0] PTR_MOVP = 7'd2;

  typedef struct packed {
    logic       romRd;
    logic       ramRd;
    logic       ramWr;
    logic [7:0] ramAddr;
    logic       useOpndAddr;
    wrSel_t     wrSel;
    logic [7:0] wrConst;
    logic [3:0] aluOp;
    logic       aluUsePc;
    logic       aluInc;
    logic       pcLoad;
    logic       capOpc;
    logic       capOp2;
    logic       capAcc;
    logic       capPsw;
    logic       capAlu;
  } strobe_t;

endpackage

// File: rtl/mcu_seq_ctrl.sv
module mcu_seq_ctrl
  import mcu_seq_pkg::*;
#(
  parameter int PORT_COUNT = NUM_PORTS
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       decSecond,
  input  logic       decThird,
  input  logic [6:0] decPtr,
  output strobe_t    st
);

  localparam logic [ES_W-1:0] ES_SP       = ES_W'(PORT_COUNT);
  localparam logic [ES_W-1:0] ES_RST_LAST = ES_W'(PORT_COUNT + 1);
  localparam logic [ES_W-1:0] ES_LAST     = '1;

  cpuState_t       state;
  logic [ES_W-1:0] es;
  logic            ptrKnown;

  assign ptrKnown = (decPtr == PTR_RLC) || (decPtr == PTR_MOVP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= CPU_RST;
      es    <= '0;
    end else begin
      unique case (state)
        CPU_RST: begin
          if (es == ES_RST_LAST) begin
            state <= CPU_FETCH;
            es    <= '0;
          end else begin
            es <= es + 1'b1;
          end
        end
        CPU_FETCH: begin
          if (es == ES_LAST) state <= CPU_EXEC;
          es <= es + 1'b1;
        end
        CPU_EXEC: begin
          if ((es == '0 && !ptrKnown) || es == ES_LAST) begin
            state <= CPU_FETCH;
            es    <= '0;
          end else begin
            es <= es + 1'b1;
          end
        end
        default: begin
          state <= CPU_RST;
          es    <= '0;
        end
      endcase
    end
  end

  always_comb begin
    st = '0;
    if (rstN) begin
      unique case (state)
        CPU_RST: begin
          if (es < ES_SP) begin
            st.ramWr   = 1'b1;
            st.ramAddr = PORT_BASE + PORT_STRIDE * 8'(es);
            st.wrSel   = WR_CONST;
            st.wrConst = PORT_INIT;
          end else if (es == ES_SP) begin
            st.ramWr   = 1'b1;
            st.ramAddr = ADDR_SP;
            st.wrSel   = WR_CONST;
            st.wrConst = SP_INIT;
          end
        end
        CPU_FETCH: begin
          case (int'(es))
            0: begin
              st.romRd    = 1'b1;
              st.aluOp    = ALU_PCADD;
              st.aluUsePc = 1'b1;
              st.aluInc   = 1'b1;
              st.pcLoad   = 1'b1;
            end
            1: begin
              st.ramRd   = 1'b1;
              st.ramAddr = ADDR_ACC;
            end
            2: begin
              st.ramRd   = 1'b1;
              st.ramAddr = ADDR_PSW;
            end
            3: begin
              st.capOpc = 1'b1;
              if (decSecond) begin
                st.romRd    = 1'b1;
                st.aluOp    = ALU_PCADD;
                st.aluUsePc = 1'b1;
                st.aluInc   = 1'b1;
                st.pcLoad   = 1'b1;
              end
            end
            4: begin
              st.capAcc   = 1'b1;
              st.romRd    = 1'b1;
              st.aluOp    = ALU_PCADD;
              st.aluUsePc = 1'b1;
              st.aluInc   = decThird;
              st.pcLoad   = 1'b1;
            end
            5: st.capPsw = 1'b1;
            6: st.capOp2 = 1'b1;
            default: ;
          endcase
        end
        CPU_EXEC: begin
          if (decPtr == PTR_RLC) begin
            case (int'(es))
              0: begin
                st.aluOp  = ALU_RLC;
                st.capAlu = 1'b1;
              end
              1: begin
                st.ramWr   = 1'b1;
                st.ramAddr = ADDR_ACC;
                st.wrSel   = WR_ALU;
              end
              2: begin
                st.ramWr   = 1'b1;
                st.ramAddr = ADDR_PSW;
                st.wrSel   = WR_PSW;
              end
              default: ;
            endcase
          end else if (decPtr == PTR_MOVP && es == '0) begin
            st.ramWr       = 1'b1;
            st.useOpndAddr = 1'b1;
            st.wrSel       = WR_ACC;
          end
        end
        default: ;
      endcase
    end
  end

  // R1: quiet buses while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> !(st.romRd || st.ramRd || st.ramWr));

  // R2: the reset sequence hands over to fetch after its last step
  p_reset_to_fetch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == CPU_RST && es == ES_RST_LAST) |=> (state == CPU_FETCH && es == '0));

  // R9: a full fetch is always followed by execute step 0
  p_fetch_to_exec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == CPU_FETCH && es == ES_LAST) |=> (state == CPU_EXEC && es == '0));

  // R9: the last execute step clears the ALU request and returns to fetch
  p_exec_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == CPU_EXEC && es == ES_LAST) |-> (st.aluOp == ALU_NONE) ##1 (state == CPU_FETCH && es == '0));

  // R10: an unknown pointer leaves execute after step 0
  p_nop_return_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == CPU_EXEC && es == '0 && !ptrKnown) |-> !st.ramWr ##1 (state == CPU_FETCH));

endmodule

// File: rtl/mcu_seq_dpath.sv
module mcu_seq_dpath
  import mcu_seq_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic [7:0]      romData,
  input  logic [7:0]      ramRdData,
  input  logic [PC_W-1:0] aluResult,
  input  logic            aluCarry,
  input  logic [6:0]      decPtrIn,
  input  logic            decThirdIn,
  output logic [PC_W-1:0] romAddr,
  output logic [7:0]      ramAddr,
  output logic [7:0]      ramWrData,
  output logic [PC_W-1:0] aluA,
  output logic [7:0]      aluB,
  output logic            aluCin,
  output logic [7:0]      decIn,
  output logic [6:0]      decPtr,
  output logic            decThird
);

  localparam int PAD_W = PC_W - 8;

  logic [PC_W-1:0] pc;
  logic [7:0]      opcReg, op2Reg, accReg, pswReg, resReg;
  logic            cReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      opcReg   <= '0;
      op2Reg   <= '0;
      accReg   <= '0;
      pswReg   <= '0;
      resReg   <= '0;
      cReg     <= 1'b0;
      decPtr   <= '0;
      decThird <= 1'b0;
    end else begin
      if (st.pcLoad) pc <= aluResult;
      if (st.capOpc) begin
        opcReg   <= romData;
        decPtr   <= decPtrIn;
        decThird <= decThirdIn;
      end
      if (st.capOp2) op2Reg <= romData;
      if (st.capAcc) accReg <= ramRdData;
      if (st.capPsw) pswReg <= ramRdData;
      if (st.capAlu) begin
        resReg <= aluResult[7:0];
        cReg   <= aluCarry;
      end
    end
  end

  assign romAddr = pc;
  assign decIn   = st.capOpc ? romData : opcReg;
  assign ramAddr = st.useOpndAddr ? op2Reg : st.ramAddr;
  assign aluA    = st.aluUsePc ? pc : {{PAD_W{1'b0}}, accReg};
  assign aluB    = {7'b0, st.aluInc};
  assign aluCin  = pswReg[7];

  always_comb begin
    unique case (st.wrSel)
      WR_CONST: ramWrData = st.wrConst;
      WR_ACC:   ramWrData = accReg;
      WR_ALU:   ramWrData = resReg;
      WR_PSW:   ramWrData = {cReg, pswReg[6:0]};
      default:  ramWrData = st.wrConst;
    endcase
  end

  // R6: opcode and memory captures happen three steps after their strobes
  p_opc_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.capOpc |-> $past(st.romRd, 3));
  p_acc_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.capAcc |-> $past(st.ramRd, 3));
  p_psw_delay_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.capPsw |-> $past(st.ramRd, 3));

  // R7: a status write keeps the low seven status bits
  p_psw_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.ramWr && st.wrSel == WR_PSW) |-> (ramWrData[6:0] == pswReg[6:0]));

  // R3: every PC load comes with a PC add request
  p_pc_via_alu_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.pcLoad |-> (st.aluOp == ALU_PCADD && st.aluUsePc));

endmodule

// File: rtl/mcu_fetch_exec_seq.sv
module mcu_fetch_exec_seq
  import mcu_seq_pkg::*;
#(
  parameter int PC_W       = 12,
  parameter int PORT_COUNT = NUM_PORTS
) (
  input  logic            clk,
  input  logic            rstN,
  output logic [PC_W-1:0] romAddr,
  output logic            romRd,
  input  logic [7:0]      romData,
  output logic [7:0]      ramAddr,
  output logic            ramRd,
  output logic            ramWr,
  output logic [7:0]      ramWrData,
  input  logic [7:0]      ramRdData,
  output logic [3:0]      aluOp,
  output logic [PC_W-1:0] aluA,
  output logic [7:0]      aluB,
  output logic            aluCin,
  input  logic [PC_W-1:0] aluResult,
  input  logic            aluCarry,
  output logic [7:0]      decIn,
  input  logic [8:0]      decOut
);

  strobe_t    st;
  logic [6:0] decPtr;
  logic       decThird;

  mcu_seq_ctrl #(.PORT_COUNT(PORT_COUNT)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .decSecond (decOut[7]),
    .decThird  (decThird),
    .decPtr    (decPtr),
    .st        (st)
  );

  mcu_seq_dpath #(.PC_W(PC_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .romData    (romData),
    .ramRdData  (ramRdData),
    .aluResult  (aluResult),
    .aluCarry   (aluCarry),
    .decPtrIn   (decOut[6:0]),
    .decThirdIn (decOut[8]),
    .romAddr    (romAddr),
    .ramAddr    (ramAddr),
    .ramWrData  (ramWrData),
    .aluA       (aluA),
    .aluB       (aluB),
    .aluCin     (aluCin),
    .decIn      (decIn),
    .decPtr     (decPtr),
    .decThird   (decThird)
  );

  assign romRd = st.romRd;
  assign ramRd = st.ramRd;
  assign ramWr = st.ramWr;
  assign aluOp = st.aluOp;

endmodule

// File: tb/mcu_fetch_exec_seq_tb.sv
module mcu_fetch_exec_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 12;
  localparam int NINSTR     = 60;
  localparam int WATCHDOG   = 5000;

  logic            clk = 1'b0;
  logic            rstN;
  logic [PC_W-1:0] romAddr;
  logic            romRd;
  logic [7:0]      romData;
  logic [7:0]      ramAddr;
  logic            ramRd, ramWr;
  logic [7:0]      ramWrData, ramRdData;
  logic [3:0]      aluOp;
  logic [PC_W-1:0] aluA, aluResult;
  logic [7:0]      aluB;
  logic            aluCin, aluCarry;
  logic [7:0]      decIn;
  logic [8:0]      decOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcu_fetch_exec_seq u_dut (
    .clk(clk), .rstN(rstN), .romAddr(romAddr), .romRd(romRd), .romData(romData),
    .ramAddr(ramAddr), .ramRd(ramRd), .ramWr(ramWr), .ramWrData(ramWrData),
    .ramRdData(ramRdData), .aluOp(aluOp), .aluA(aluA), .aluB(aluB), .aluCin(aluCin),
    .aluResult(aluResult), .aluCarry(aluCarry), .decIn(decIn), .decOut(decOut)
  );

  // bench arithmetic unit
  always_comb begin
    aluResult = '0;
    aluCarry  = 1'b0;
    case (aluOp)
      4'h1: aluResult = aluA + PC_W'(aluB);
      4'hB: begin
        aluResult = {{(PC_W-8){1'b0}}, aluA[6:0], aluCin};
        aluCarry  = aluA[7];
      end
      default: ;
    endcase
  end

  // bench decoder: {third-step flag, second-byte flag, pointer}
  function automatic logic [8:0] decodeOp(input logic [7:0] op);
    case (op)
      8'h33:   return {1'b0, 1'b0, 7'd1};
      8'hF5:   return {1'b0, 1'b1, 7'd2};
      8'h74:   return {1'b0, 1'b1, 7'h30};
      8'hA5:   return {1'b1, 1'b1, 7'h55};
      default: return 9'h000;
    endcase
  endfunction
  assign decOut = decodeOp(decIn);

  // memories: data valid only in the third cycle after a strobe, poison otherwise
  logic [7:0] rom [256];
  logic [7:0] ram [256];
  logic [7:0] initAcc, initPsw;
  logic       rv1, rv2, qv1, qv2;
  logic [7:0] ra1, ra2, qa1, qa2;

  always @(posedge clk) begin
    rv1 <= romRd; ra1 <= romAddr[7:0]; rv2 <= rv1; ra2 <= ra1;
    qv1 <= ramRd; qa1 <= ramAddr;      qv2 <= qv1; qa2 <= qa1;
    romData   <= rv2 ? rom[ra2] : 8'hEE;
    ramRdData <= qv2 ? ram[qa2] : 8'hEE;
    if (!rstN) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
      ram[8'hE0] <= initAcc;
      ram[8'hD0] <= initPsw;
    end else if (ramWr) begin
      ram[ramAddr] <= ramWrData;
    end
  end

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected write queue
  int         qCyc [512];
  logic [7:0] qAddr [512];
  logic [7:0] qData [512];
  string      qTag [512];
  int         qHead = 0, qTail = 0;

  task automatic push(input int c, input logic [7:0] a, input logic [7:0] d, input string t);
    qCyc[qTail] = c; qAddr[qTail] = a; qData[qTail] = d; qTag[qTail] = t;
    qTail++;
  endtask

  // reference model state
  logic [7:0] mRam [256];
  logic [7:0] mAcc, mPsw;
  int         cyc;
  int         nextOpc, curOpc, expPc, pcAtOpc, progEnd;
  bit         curValid, curB7, curB8, done;
  logic [6:0] curPtr;
  logic [7:0] rlcA;
  logic       rlcC;

  always @(posedge clk) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      chk(!romRd && !ramRd && !ramWr && aluOp == 4'h0 && romAddr == '0,
          "R1 reset quiet", int'({romRd, ramRd, ramWr, aluOp}), 0);
    end else if (!done) begin
      if (cyc == nextOpc) begin
        if (expPc == progEnd) begin
          done = 1'b1;
        end else begin
          logic [8:0] d;
          logic [7:0] op2;
          chk(romRd && romAddr == PC_W'(expPc), "R3 opcode fetch address", int'(romAddr), expPc);
          chk(aluOp == 4'h1 && aluA == PC_W'(expPc) && aluB == 8'd1, "R3 pc add request",
              int'({aluOp, aluB}), int'({4'h1, 8'd1}));
          d        = decodeOp(rom[expPc[7:0]]);
          op2      = rom[8'(expPc + 1)];
          curOpc   = cyc;
          curValid = 1'b1;
          curB7    = d[7];
          curB8    = d[8];
          curPtr   = d[6:0];
          pcAtOpc  = expPc;
          expPc    = expPc + 1 + int'(d[7]) + int'(d[8]);
          if (d[6:0] == 7'd1) begin
            rlcA = mAcc;
            rlcC = mPsw[7];
            mAcc = {rlcA[6:0], rlcC};
            mPsw = {rlcA[7], mPsw[6:0]};
            mRam[8'hE0] = mAcc;
            mRam[8'hD0] = mPsw;
            push(cyc + 9,  8'hE0, mAcc, "R7 accumulator write");
            push(cyc + 10, 8'hD0, mPsw, "R7 status write");
            nextOpc = cyc + 16;
          end else if (d[6:0] == 7'd2) begin
            mRam[op2] = mAcc;
            push(cyc + 8, op2, mAcc, "R8 move write");
            nextOpc = cyc + 16;
          end else begin
            nextOpc = cyc + 9;
          end
        end
      end
      if (!done) begin
        bit expRom, expRam;
        expRom = curValid && (cyc == curOpc || (cyc == curOpc + 3 && curB7) || cyc == curOpc + 4);
        chk(romRd == expRom, "R4 rom strobe pattern", int'(romRd), int'(expRom));
        expRam = curValid && (cyc == curOpc + 1 || cyc == curOpc + 2);
        chk(ramRd == expRam, "R6 ram read strobe pattern", int'(ramRd), int'(expRam));
        if (curValid && cyc == curOpc + 1)
          chk(ramAddr == 8'hE0, "R6 accumulator read address", int'(ramAddr), 'hE0);
        if (curValid && cyc == curOpc + 2)
          chk(ramAddr == 8'hD0, "R6 status read address", int'(ramAddr), 'hD0);
        if (curValid && cyc == curOpc + 3 && curB7)
          chk(romAddr == PC_W'(pcAtOpc + 1) && aluOp == 4'h1 && aluB == 8'd1,
              "R4 second byte fetch", int'(romAddr), pcAtOpc + 1);
        if (curValid && cyc == curOpc + 4)
          chk(romAddr == PC_W'(pcAtOpc + 1 + int'(curB7)) && aluOp == 4'h1 && aluB == {7'b0, curB8},
              "R5 third byte fetch", int'({romAddr, aluB}), int'({12'(pcAtOpc + 1 + int'(curB7)), 7'b0, curB8}));
        if (curValid && cyc == curOpc + 8 && curPtr == 7'd1)
          chk(aluOp == 4'hB && aluA == {4'b0, rlcA} && aluCin == rlcC, "R7 rotate request",
              int'({aluOp, aluA[7:0], aluCin}), int'({4'hB, rlcA, rlcC}));
        if (curValid && cyc >= curOpc + 8 && curPtr == 7'd2)
          chk(aluOp == 4'h0, "R8 no ALU during move", int'(aluOp), 0);
        if (curValid && cyc == curOpc + 15 && (curPtr == 7'd1 || curPtr == 7'd2))
          chk(aluOp == 4'h0, "R9 ALU cleared at ES7", int'(aluOp), 0);
        if (qHead < qTail && qCyc[qHead] == cyc) begin
          chk(ramWr && ramAddr == qAddr[qHead] && ramWrData == qData[qHead], qTag[qHead],
              int'({ramWr, ramAddr, ramWrData}), int'({1'b1, qAddr[qHead], qData[qHead]}));
          qHead++;
        end else begin
          chk(!ramWr, "R10 no unexpected write", int'({ramWr, ramAddr}), 0);
        end
      end
    end
  end

  initial begin
    int pos;
    void'($urandom(32'd20240607));
    rstN = 1'b0;
    done = 1'b0;
    curValid = 1'b0;
    curOpc = -100;
    for (int i = 0; i < 256; i++) begin
      rom[i]  = 8'h00;
      mRam[i] = 8'h00;
    end
    // directed corners first: rotate of 80h with carry 0, moves, multi-byte unknowns
    pos = 0;
    rom[pos++] = 8'h33;
    rom[pos++] = 8'hF5; rom[pos++] = 8'h80;
    rom[pos++] = 8'h33;
    rom[pos++] = 8'hA5; rom[pos++] = 8'h33; rom[pos++] = 8'hF5;
    rom[pos++] = 8'h74; rom[pos++] = 8'hF5;
    rom[pos++] = 8'hF5; rom[pos++] = 8'h90;
    rom[pos++] = 8'h00;
    for (int i = 0; i < NINSTR; i++) begin
      int r;
      r = int'($urandom % 5);
      case (r)
        0: rom[pos++] = 8'h33;
        1: begin rom[pos++] = 8'hF5; rom[pos++] = 8'h80 + 8'(($urandom % 4) * 16); end
        2: rom[pos++] = 8'h00;
        3: begin rom[pos++] = 8'h74; rom[pos++] = 8'($urandom); end
        default: begin rom[pos++] = 8'hA5; rom[pos++] = 8'($urandom); rom[pos++] = 8'($urandom); end
      endcase
    end
    progEnd = pos;
    initAcc = 8'h80;
    initPsw = 8'h5A;
    mAcc = initAcc;
    mPsw = initPsw;
    mRam[8'hE0] = initAcc;
    mRam[8'hD0] = initPsw;
    for (int p = 0; p < 4; p++) begin
      push(p, 8'h80 + 8'(p * 16), 8'hFF, "R2 port init write");
      mRam[8'h80 + 8'(p * 16)] = 8'hFF;
    end
    push(4, 8'h81, 8'h07, "R2 stack pointer init write");
    mRam[8'h81] = 8'h07;
    nextOpc = 6;
    expPc   = 0;

    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    while (!done && cyc < WATCHDOG) @(negedge clk);
    if (!done) chk(1'b0, "watchdog expired", cyc, WATCHDOG);

    repeat (4) @(negedge clk);
    chk(qHead == qTail, "R9 all expected writes seen", qHead, qTail);
    chk(ram[8'hE0] == mRam[8'hE0], "R7 final accumulator", int'(ram[8'hE0]), int'(mRam[8'hE0]));
    chk(ram[8'hD0] == mRam[8'hD0], "R7 final status", int'(ram[8'hD0]), int'(mRam[8'hD0]));
    chk(ram[8'h81] == 8'h07, "R2 final stack pointer", int'(ram[8'h81]), 7);
    for (int p = 0; p < 4; p++)
      chk(ram[8'h80 + 8'(p * 16)] == mRam[8'h80 + 8'(p * 16)], "R8 final port value",
          int'(ram[8'h80 + 8'(p * 16)]), int'(mRam[8'h80 + 8'(p * 16)]));

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule